// File: doc/BRIEF.md
# Settings Save and Restore Sequencer

This block decides when the two wiper bytes and the configuration byte of a dual audio attenuator are copied into a small on-chip nonvolatile memory, and when they are read back. The memory has three byte locations. Location 0 holds wiper 0, location 1 holds wiper 1, and location 2 holds the configuration byte. The memory is reached through a word-wide read and write port. Each write is acknowledged by a one-cycle completion pulse once the memory's own write latency has run out. Reads return data one cycle after the read strobe.

Coming out of reset, the sequencer reads the three locations and keeps the wipers muted while it does so. It then presents the restored settings. After that it waits for a bus STOP that ends a write transaction which changed the registers. If the part is in nonvolatile mode, that STOP starts a save of all three locations. When zero-crossing updating is enabled and an update is still outstanding, the save is held back until the update completes. While a save or the restore is under way, the `busy` output tells the bus interface to refuse its slave address.

The configuration byte is decoded as follows. Bit 2 set means volatile mode. Bit 1 set enables zero-crossing updating. Bit 0 set selects the 33-step scale, whose mute code is 33. Bit 0 clear selects the 63-step scale, whose mute code is 63. The reset value is 87h.

Top module: `nvstore_seq`

## Requirements
- R1: After reset release, the block reads locations 0, 1 and 2 in that order, one read per two cycles. `busy` and `restore_muted` are high for exactly the first 6 cycles. Until the load completes, the restored configuration reads 87h and both restored wipers read 33.
- R2: When the load completes, `restored_config` takes the byte read from location 2. If that byte has bit 2 set, both restored wipers show the mute code, which is 33 when bit 0 is 1 and 63 when bit 0 is 0. Otherwise the restored wipers show bits 5:0 of locations 0 and 1.
- R3: A STOP sampled with `regs_dirty`=1, `nv_mode`=1 and `busy`=0, and with no zero-crossing update outstanding, raises `busy` on the next cycle. The first write strobe follows one cycle after that.
- R4: A save writes exactly three times, to addresses 0, 1 and 2 in that order. Each write strobe lasts one cycle. The data written are `wiper0_reg`, `wiper1_reg` and `config_reg` as sampled on the cycle before the first strobe.
- R5: Each write after the first is issued on the cycle after the previous write's `mem_wr_done` pulse. `busy` falls on the cycle after the last completion pulse.
- R6: A STOP with `nv_mode`=0, or with `regs_dirty`=0, causes no memory write and leaves `busy` low.
- R7: A STOP sampled with `zcd_enable`=1 and `zcd_done`=0 raises `busy` but issues no write until `zcd_done` is sampled high. The first strobe then comes two cycles later.
- R8: A STOP that arrives while `busy` is high is ignored. This covers a STOP during the restore, during a zero-crossing hold and during a save. Such a STOP neither starts a second save nor lengthens the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| stop_detected | input | 1 | One-cycle pulse: bus STOP seen after a write transaction |
| regs_dirty | input | 1 | The finished transaction changed a register |
| nv_mode | input | 1 | 1 = registers are kept in nonvolatile storage |
| zcd_enable | input | 1 | Zero-crossing updating enabled |
| zcd_done | input | 1 | No zero-crossing wiper update is outstanding |
| wiper0_reg | input | 8 | Current wiper 0 register byte |
| wiper1_reg | input | 8 | Current wiper 1 register byte |
| config_reg | input | 8 | Current configuration register byte |
| mem_write_en | output | 1 | Memory write strobe |
| mem_read_en | output | 1 | Memory read strobe |
| mem_addr | output | 2 | Memory location |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the read strobe |
| mem_wr_done | input | 1 | One-cycle pulse: the last write has finished |
| busy | output | 1 | Restore or save in progress; refuse the slave address |
| restore_muted | output | 1 | Wipers must be held at mute while the load runs |
| restored_wiper0 | output | 6 | Wiper 0 position after power-up |
| restored_wiper1 | output | 6 | Wiper 1 position after power-up |
| restored_config | output | 8 | Configuration byte after power-up |

## Verification
The bench runs a behavioural memory with an adjustable write latency. A cycle-accurate reference model checks `busy`, the write strobe, the address and the data on every clock.

A save is first triggered with zero-crossing updating off at latencies of 3 and 1. Comparing these two runs separates a sequencer that waits for the completion pulse from one that counts cycles itself. Two further STOPs carry `nv_mode` low and `regs_dirty` low. They show that the trigger checks each qualifier. A held save with `zcd_done` kept low for many cycles shows that the write waits for the zero-crossing update and is not simply delayed by a fixed amount.

Extra STOPs are sent during a save, during a zero-crossing hold and during the restore; these expose any re-arming. Three resets follow. One uses a stored image in nonvolatile mode. The other two use volatile images, one for each scale. Together they tell apart loading the stored wipers, choosing the 33 mute code and choosing the 63 mute code.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int POS_W   = 6;
    localparam int NUM_LOC = 3;

    typedef logic [DATA_W-1:0] nvs_byte_t;
    typedef logic [ADDR_W-1:0] nvs_addr_t;
    typedef logic [POS_W-1:0]  nvs_pos_t;
    typedef logic [NUM_LOC-1:0][DATA_W-1:0] nvs_image_t;

    localparam nvs_addr_t LAST_LOC = nvs_addr_t'(NUM_LOC - 1);

    localparam int CFG_VOLATILE_BIT = 2;
    localparam int CFG_SHORT_BIT    = 0;
    localparam nvs_byte_t CFG_RESET = 8'h87;
    localparam nvs_pos_t  MUTE_SHORT = nvs_pos_t'(33);
    localparam nvs_pos_t  MUTE_LONG  = nvs_pos_t'(63);

    function automatic nvs_pos_t mute_code(input nvs_byte_t cfg);
        return cfg[CFG_SHORT_BIT] ? MUTE_SHORT : MUTE_LONG;
    endfunction
endpackage

// File: rtl/nvs_loader.sv
module nvs_loader
    import nvs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  nvs_byte_t rd_data,
    output logic      rd_en,
    output nvs_addr_t rd_addr,
    output logic      active,
    output nvs_pos_t  wiper0_o,
    output nvs_pos_t  wiper1_o,
    output nvs_byte_t cfg_o
);
    typedef enum logic [1:0] {L_READ, L_CAPTURE, L_READY} lstate_t;

    typedef struct packed {
        lstate_t   state;
        nvs_addr_t idx;
        nvs_pos_t  raw0;
        nvs_pos_t  raw1;
        nvs_pos_t  wip0;
        nvs_pos_t  wip1;
        nvs_byte_t cfg;
    } lreg_t;

    lreg_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        case (ld_q.state)
            L_READ: ld_d.state = L_CAPTURE;
            L_CAPTURE: begin
                if (ld_q.idx == LAST_LOC) begin
                    ld_d.cfg   = rd_data;
                    ld_d.state = L_READY;
                    if (rd_data[CFG_VOLATILE_BIT]) begin
                        ld_d.wip0 = mute_code(rd_data);
                        ld_d.wip1 = mute_code(rd_data);
                    end else begin
                        ld_d.wip0 = ld_q.raw0;
                        ld_d.wip1 = ld_q.raw1;
                    end
                end else begin
                    if (ld_q.idx == nvs_addr_t'(0)) ld_d.raw0 = rd_data[POS_W-1:0];
                    else                            ld_d.raw1 = rd_data[POS_W-1:0];
                    ld_d.idx   = nvs_addr_t'(ld_q.idx + 1'b1);
                    ld_d.state = L_READ;
                end
            end
            default: ld_d.state = L_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q.state <= L_READ;
            ld_q.idx   <= '0;
            ld_q.raw0  <= '0;
            ld_q.raw1  <= '0;
            ld_q.wip0  <= mute_code(CFG_RESET);
            ld_q.wip1  <= mute_code(CFG_RESET);
            ld_q.cfg   <= CFG_RESET;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign rd_en    = (ld_q.state == L_READ);
    assign rd_addr  = ld_q.idx;
    assign active   = (ld_q.state != L_READY);
    assign wiper0_o = ld_q.wip0;
    assign wiper1_o = ld_q.wip1;
    assign cfg_o    = ld_q.cfg;

    // R1: once the load has finished it never restarts before the next reset
    a_r1_load_once: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active);
    // R2: restored values hold once the load has finished
    a_r2_restore_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(wiper0_o) && $stable(wiper1_o) && $stable(cfg_o)));
endmodule

// File: rtl/nvs_trigger.sv
module nvs_trigger
    import nvs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_detected,
    input  logic regs_dirty,
    input  logic nv_mode,
    input  logic zcd_enable,
    input  logic zcd_done,
    input  logic blocked,
    output logic start,
    output logic pending
);
    typedef enum logic {T_IDLE, T_HOLD} tstate_t;

    typedef struct packed {
        tstate_t state;
        logic    start;
    } treg_t;

    treg_t tr_d, tr_q;
    logic  accept;

    assign accept = (tr_q.state == T_IDLE) && !tr_q.start && !blocked &&
                    stop_detected && regs_dirty && nv_mode;

    always_comb begin
        tr_d       = tr_q;
        tr_d.start = 1'b0;
        case (tr_q.state)
            T_IDLE: begin
                if (accept) begin
                    if (zcd_enable && !zcd_done) tr_d.state = T_HOLD;
                    else                         tr_d.start = 1'b1;
                end
            end
            default: begin
                if (!zcd_enable || zcd_done) begin
                    tr_d.start = 1'b1;
                    tr_d.state = T_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr_q.state <= T_IDLE;
            tr_q.start <= 1'b0;
        end else begin
            tr_q <= tr_d;
        end
    end

    assign start   = tr_q.start;
    assign pending = (tr_q.state == T_HOLD) || tr_q.start;

    // R7: no save starts while a zero-crossing update is outstanding
    a_r7_hold_for_zcd: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_q.state == T_HOLD && zcd_enable && !zcd_done) |=> !start);
    // R8: a start is a single pulse, never repeated back to back
    a_r8_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/nvs_writer.sv
module nvs_writer
    import nvs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  nvs_image_t image_in,
    input  logic       wr_done,
    output logic       wr_en,
    output nvs_addr_t  wr_addr,
    output nvs_byte_t  wr_data,
    output logic       active
);
    typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT} wstate_t;

    typedef struct packed {
        wstate_t    state;
        nvs_addr_t  idx;
        nvs_image_t snap;
    } wreg_t;

    wreg_t wr_d, wr_q;

    always_comb begin
        wr_d = wr_q;
        case (wr_q.state)
            W_IDLE: begin
                if (start) begin
                    wr_d.snap  = image_in;
                    wr_d.idx   = '0;
                    wr_d.state = W_ISSUE;
                end
            end
            W_ISSUE: wr_d.state = W_WAIT;
            W_WAIT: begin
                if (wr_done) begin
                    if (wr_q.idx == LAST_LOC) begin
                        wr_d.state = W_IDLE;
                    end else begin
                        wr_d.idx   = nvs_addr_t'(wr_q.idx + 1'b1);
                        wr_d.state = W_ISSUE;
                    end
                end
            end
            default: wr_d.state = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q.state <= W_IDLE;
            wr_q.idx   <= '0;
            wr_q.snap  <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign wr_en   = (wr_q.state == W_ISSUE);
    assign wr_addr = wr_q.idx;
    assign wr_data = wr_q.snap[wr_q.idx];
    assign active  = (wr_q.state != W_IDLE);

    // R4: every write strobe lasts a single cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R5: no new strobe until the memory reports completion
    a_r5_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q.state == W_WAIT && !wr_done) |=> !wr_en);
    // R5: the sequence stays active after a strobe
    a_r5_active_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> active);
endmodule

// File: rtl/nvstore_seq.sv
module nvstore_seq
    import nvs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stop_detected,
    input  logic                      regs_dirty,
    input  logic                      nv_mode,
    input  logic                      zcd_enable,
    input  logic                      zcd_done,
    input  logic [nvs_pkg::DATA_W-1:0] wiper0_reg,
    input  logic [nvs_pkg::DATA_W-1:0] wiper1_reg,
    input  logic [nvs_pkg::DATA_W-1:0] config_reg,
    output logic                      mem_write_en,
    output logic                      mem_read_en,
    output logic [nvs_pkg::ADDR_W-1:0] mem_addr,
    output logic [nvs_pkg::DATA_W-1:0] mem_wdata,
    input  logic [nvs_pkg::DATA_W-1:0] mem_rdata,
    input  logic                      mem_wr_done,
    output logic                      busy,
    output logic                      restore_muted,
    output logic [nvs_pkg::POS_W-1:0]  restored_wiper0,
    output logic [nvs_pkg::POS_W-1:0]  restored_wiper1,
    output logic [nvs_pkg::DATA_W-1:0] restored_config
);
    logic       load_active, load_rd_en;
    nvs_addr_t  load_addr;
    logic       trig_start, trig_pending;
    logic       save_active, save_wr_en;
    nvs_addr_t  save_addr;
    nvs_byte_t  save_data;
    nvs_image_t image;

    assign image = {config_reg, wiper1_reg, wiper0_reg};

    nvs_loader u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_data  (mem_rdata),
        .rd_en    (load_rd_en),
        .rd_addr  (load_addr),
        .active   (load_active),
        .wiper0_o (restored_wiper0),
        .wiper1_o (restored_wiper1),
        .cfg_o    (restored_config)
    );

    nvs_trigger u_trigger (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_detected (stop_detected),
        .regs_dirty    (regs_dirty),
        .nv_mode       (nv_mode),
        .zcd_enable    (zcd_enable),
        .zcd_done      (zcd_done),
        .blocked       (load_active || save_active),
        .start         (trig_start),
        .pending       (trig_pending)
    );

    nvs_writer u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (trig_start),
        .image_in (image),
        .wr_done  (mem_wr_done),
        .wr_en    (save_wr_en),
        .wr_addr  (save_addr),
        .wr_data  (save_data),
        .active   (save_active)
    );

    assign mem_read_en   = load_rd_en;
    assign mem_write_en  = save_wr_en;
    assign mem_addr      = load_active ? load_addr : save_addr;
    assign mem_wdata     = save_data;
    assign busy          = load_active || trig_pending || save_active;
    assign restore_muted = load_active;

    // R3: a write is only ever issued while the block reports busy
    a_r3_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write_en |-> busy);
    // R1: muting during the load implies busy
    a_r1_muted_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
        restore_muted |-> busy);
    // R1: reads and writes never overlap
    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read_en && mem_write_en));
endmodule

// File: tb/nvstore_seq_test.sv
module nvstore_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_detected = 1'b0, regs_dirty = 1'b0, nv_mode = 1'b0;
    logic zcd_enable = 1'b0, zcd_done = 1'b1;
    logic [7:0] wiper0_reg = 8'h00, wiper1_reg = 8'h40, config_reg = 8'h87;
    logic mem_write_en, mem_read_en;
    logic [1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic mem_wr_done = 1'b0;
    logic busy, restore_muted;
    logic [5:0] restored_wiper0, restored_wiper1;
    logic [7:0] restored_config;

    nvstore_seq uut (
        .clk(clk), .rst_n(rst_n), .stop_detected(stop_detected),
        .regs_dirty(regs_dirty), .nv_mode(nv_mode), .zcd_enable(zcd_enable),
        .zcd_done(zcd_done), .wiper0_reg(wiper0_reg), .wiper1_reg(wiper1_reg),
        .config_reg(config_reg), .mem_write_en(mem_write_en),
        .mem_read_en(mem_read_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_wr_done(mem_wr_done), .busy(busy),
        .restore_muted(restore_muted), .restored_wiper0(restored_wiper0),
        .restored_wiper1(restored_wiper1), .restored_config(restored_config)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // behavioural memory with programmable write latency
    logic [7:0] mem [3];
    int lat = 3;
    int lat_cnt = 0;
    int wr_count = 0;

    always @(posedge clk) begin
        if (mem_write_en) begin
            mem[mem_addr] <= mem_wdata;
            lat_cnt       <= lat;
            mem_wr_done   <= 1'b0;
            wr_count      <= wr_count + 1;
        end else begin
            mem_wr_done <= (lat_cnt == 1);
            if (lat_cnt > 0) lat_cnt <= lat_cnt - 1;
        end
        if (mem_read_en) mem_rdata <= mem[mem_addr];
    end

    // reference model
    int m_load, m_step;
    bit m_zw, m_start, m_issue, n_start, n_zw, blk;
    logic [7:0] m_snap [3];
    logic [5:0] e_w0, e_w1;
    logic [7:0] e_cfg;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_load = 6; m_zw = 0; m_start = 0; m_step = -1; m_issue = 0;
            e_w0 = 6'd33; e_w1 = 6'd33; e_cfg = 8'h87;
        end else begin
            blk = (m_load > 0) || m_zw || m_start || (m_step >= 0);
            n_start = 0; n_zw = m_zw;
            if (m_zw) begin
                if (!zcd_enable || zcd_done) begin n_start = 1; n_zw = 0; end
            end else if (!blk && stop_detected && regs_dirty && nv_mode) begin
                if (zcd_enable && !zcd_done) n_zw = 1; else n_start = 1;
            end
            if (m_step < 0) begin
                if (m_start) begin
                    m_step = 0; m_issue = 1;
                    m_snap[0] = wiper0_reg; m_snap[1] = wiper1_reg; m_snap[2] = config_reg;
                end
            end else if (m_issue) begin
                m_issue = 0;
            end else if (mem_wr_done) begin
                if (m_step == 2) m_step = -1;
                else begin m_step++; m_issue = 1; end
            end
            if (m_load > 0) begin
                m_load--;
                if (m_load == 0) begin
                    e_cfg = mem[2];
                    if (mem[2][2]) begin
                        e_w0 = mem[2][0] ? 6'd33 : 6'd63;
                        e_w1 = e_w0;
                    end else begin
                        e_w0 = mem[0][5:0];
                        e_w1 = mem[1][5:0];
                    end
                end
            end
            m_start = n_start; m_zw = n_zw;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            bit e_busy, e_wr;
            e_busy = (m_load > 0) || m_zw || m_start || (m_step >= 0);
            e_wr   = (m_step >= 0) && m_issue;
            chk(busy == e_busy, "R3/R5 busy", int'(busy), int'(e_busy));
            chk(mem_write_en == e_wr, "R4 write strobe", int'(mem_write_en), int'(e_wr));
            if (e_wr && mem_write_en) begin
                chk(mem_addr == 2'(m_step), "R4 address", int'(mem_addr), m_step);
                chk(mem_wdata == m_snap[m_step], "R4 data", int'(mem_wdata), int'(m_snap[m_step]));
            end
            chk(restore_muted == (m_load > 0), "R1 muted", int'(restore_muted), int'(m_load > 0));
            chk(restored_wiper0 == e_w0, "R2 wiper0", int'(restored_wiper0), int'(e_w0));
            chk(restored_wiper1 == e_w1, "R2 wiper1", int'(restored_wiper1), int'(e_w1));
            chk(restored_config == e_cfg, "R2 config", int'(restored_config), int'(e_cfg));
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_detected = 1'b1;
        @(negedge clk) stop_detected = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic set_regs(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        @(negedge clk);
        wiper0_reg = a; wiper1_reg = b; config_reg = c;
    endtask

    int base;

    initial begin
        mem[0] = 8'h0A; mem[1] = 8'h54; mem[2] = 8'h87;
        idle(3);
        rst_n = 1'b1;
        // R1: reset state seen right after release
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy during load", int'(busy), 1);
        chk(restored_config == 8'h87, "R1 config during load", int'(restored_config), 8'h87);
        idle(10);
        // R2: volatile image with short scale gives mute code 33
        chk(restored_wiper0 == 6'd33, "R2 volatile mute", int'(restored_wiper0), 33);

        // R3 R4 R5: save with latency 3, no zero-crossing hold
        nv_mode = 1'b1; regs_dirty = 1'b1; zcd_enable = 1'b0;
        set_regs(8'h05, 8'h4C, 8'h82);
        base = wr_count;
        pulse_stop();
        idle(30);
        chk(wr_count - base == 3, "R4 write count", wr_count - base, 3);
        chk(mem[0] == 8'h05 && mem[1] == 8'h4C && mem[2] == 8'h82, "R4 stored image",
            int'({mem[0], mem[1], mem[2]}), 24'h054C82);

        // R5 R8: latency 1, second STOP during the save is ignored
        lat = 1;
        set_regs(8'h11, 8'h62, 8'h83);
        base = wr_count;
        pulse_stop();
        idle(2);
        pulse_stop();
        idle(20);
        chk(wr_count - base == 3, "R8 stop while busy", wr_count - base, 3);
        chk(busy == 1'b0, "R5 busy released", int'(busy), 0);

        // R6: volatile mode and clean registers cause no write
        base = wr_count;
        nv_mode = 1'b0;
        pulse_stop();
        idle(5);
        chk(busy == 1'b0, "R6 volatile stop", int'(busy), 0);
        nv_mode = 1'b1; regs_dirty = 1'b0;
        pulse_stop();
        idle(5);
        chk(wr_count - base == 0, "R6 no write", wr_count - base, 0);

        // R7 R8: hold for zero-crossing, extra STOP during hold
        lat = 4; regs_dirty = 1'b1; zcd_enable = 1'b1; zcd_done = 1'b0;
        set_regs(8'h2A, 8'h5D, 8'h82);
        base = wr_count;
        pulse_stop();
        idle(15);
        chk(wr_count - base == 0, "R7 held", wr_count - base, 0);
        chk(busy == 1'b1, "R7 busy while held", int'(busy), 1);
        pulse_stop();
        idle(5);
        zcd_done = 1'b1;
        idle(40);
        chk(wr_count - base == 3, "R7 released save", wr_count - base, 3);
        zcd_enable = 1'b0;

        // R2 R8: nonvolatile image restored; STOP during load ignored
        do_reset();
        idle(2);
        base = wr_count;
        pulse_stop();
        idle(20);
        chk(wr_count - base == 0, "R8 stop during load", wr_count - base, 0);
        chk(restored_wiper0 == 6'd42 && restored_wiper1 == 6'd29, "R2 stored wipers",
            int'({restored_wiper0, restored_wiper1}), int'({6'd42, 6'd29}));

        // R2: volatile image with long scale gives mute code 63
        set_regs(8'h01, 8'h41, 8'h84);
        pulse_stop();
        idle(40);
        do_reset();
        idle(10);
        chk(restored_wiper1 == 6'd63, "R2 long mute", int'(restored_wiper1), 63);
        chk(restored_config == 8'h84, "R2 config loaded", int'(restored_config), 8'h84);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule